// File: doc/BRIEF.md
# Floating-Point Register Renamer

This block sits ahead of the floating-point decoder and turns the architectural register fields of each incoming instruction into physical register names. Thirty-two architectural registers share a pool of forty physical registers. A map table holds the current physical name of every architectural register. The eight spare names sit in a circular free list.

Each instruction carries a target field and three source fields. The three sources and the target's current name are all looked up in the same cycle. The target then receives a fresh name from the head of the free list, and that name is written into the map table. The name it replaces is not freed straight away. It waits in a pending return queue until a completion strobe arrives. Each strobe moves the oldest waiting name to the tail of the free list, and the name can be handed out again from there.

The upstream stage presents one instruction per cycle on a valid line. An instruction is taken in the cycle where `ren_accept_o` is high. `stall_o` tells the upstream stage to hold its instruction.

Top module: `rn_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i in 0..31, and `stall_o` is low.
- R2: After reset, the free list hands out physical names 32, 33, ... 39 in that order. `phys_t_o` always shows the name at the head of the free list, which is the name the next accepted target receives.
- R3: Sources are looked up before the target update of the same instruction. A source equal to the target therefore returns the mapping that was in place before the instruction.
- R4: After an accepted rename, lookups of the target register return the name given in `phys_t_o` in the accepting cycle, until the register is renamed again.
- R5: A displaced physical name goes into the pending queue. Each completion strobe moves the oldest pending name to the tail of the free list. Names are reused in first-in, first-out order.
- R6: `stall_o` is high when the free list is empty or the pending queue is full. It does not depend on `ren_valid_i`.
- R7: A valid instruction presented while `stall_o` is high is not accepted. It changes neither the map table nor the free list.
- R8: A completion strobe while the pending queue is empty is ignored.
- R9: A rename and a completion in the same cycle both take effect. A completion during a stall makes a name available from the next cycle.
- R10: `ren_accept_o` equals `ren_valid_i` and not `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Instruction present |
| ren_t_i | input | 5 | Architectural target |
| ren_s1_i | input | 5 | Architectural source 1 |
| ren_s2_i | input | 5 | Architectural source 2 |
| ren_s3_i | input | 5 | Architectural source 3 |
| cmpl_i | input | 1 | Completion strobe: release oldest pending name |
| ren_accept_o | output | 1 | Instruction taken this cycle |
| stall_o | output | 1 | No rename possible this cycle |
| phys_t_o | output | 6 | Physical name for the target |
| phys_s1_o | output | 6 | Physical name for source 1 |
| phys_s2_o | output | 6 | Physical name for source 2 |
| phys_s3_o | output | 6 | Physical name for source 3 |

## Verification
A corrupted map entry shows up on a source port in the first cycle that the register is read. A wrong pointer in the free list shows up at once on `phys_t_o`. A fault in the pending queue stays hidden until its names come back around through the free list. That can take up to eight renames after the completion, or longer. A count that drifts shows first as `stall_o` rising one cycle too early or too late. For this reason the bench runs long mixed sequences, so that every name makes several round trips.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned NUM_ARCH = 32;
  localparam int unsigned NUM_PHYS = 40;
  localparam int unsigned AREG_W   = $clog2(NUM_ARCH);
  localparam int unsigned PREG_W   = $clog2(NUM_PHYS);
  localparam int unsigned SPARE    = NUM_PHYS - NUM_ARCH;
  localparam int unsigned NUM_RD   = 4;  // s1, s2, s3, old target

  typedef logic [AREG_W-1:0] areg_t;
  typedef logic [PREG_W-1:0] preg_t;
endpackage

// File: rtl/rn_name_fifo.sv
module rn_name_fifo #(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned W         = 6,
  parameter bit          INIT_FULL = 1'b0,
  parameter int unsigned INIT_BASE = 0,
  localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_o  = mem_q[head_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++)
        mem_q[i] <= INIT_FULL ? W'(INIT_BASE + i) : '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= INIT_FULL ? CNT_W'(DEPTH) : '0;
    end else begin
      if (push_i) begin
        mem_q[tail_q] <= push_data_i;
        tail_q        <= ptr_inc(tail_q);
      end
      if (pop_i) head_q <= ptr_inc(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_push_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && empty_o) |=> (head_o == $past(push_data_i)));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_ENT = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned DAT_W   = 6,
  parameter int unsigned NRD     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx_i,
  output logic [NRD-1:0][DAT_W-1:0]  rd_dat_o,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DAT_W-1:0]           wr_dat_i
);
  logic [DAT_W-1:0] map_q [NUM_ENT];

  // reads see the table before this cycle's write
  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rd_dat_o[g] = map_q[rd_idx_i[g]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_ENT); i++) map_q[i] <= DAT_W'(i);
    end else if (we_i) begin
      map_q[wr_idx_i] <= wr_dat_i;
    end
  end

  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (map_q[$past(wr_idx_i)] == $past(wr_dat_i)));
endmodule

// File: rtl/rn_renamer.sv
module rn_renamer
  import rn_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_valid_i,
  input  logic [4:0]    ren_t_i,
  input  logic [4:0]    ren_s1_i,
  input  logic [4:0]    ren_s2_i,
  input  logic [4:0]    ren_s3_i,
  input  logic          cmpl_i,
  output logic          ren_accept_o,
  output logic          stall_o,
  output logic [5:0]    phys_t_o,
  output logic [5:0]    phys_s1_o,
  output logic [5:0]    phys_s2_o,
  output logic [5:0]    phys_s3_o
);
  localparam int unsigned CNT_W = $clog2(SPARE + 1);

  logic [NUM_RD-1:0][AREG_W-1:0] rd_idx;
  logic [NUM_RD-1:0][PREG_W-1:0] rd_dat;
  preg_t            free_head, pend_head, old_t;
  logic             free_empty, free_full, pend_empty, pend_full;
  logic [CNT_W-1:0] free_cnt, pend_cnt;
  logic             accept, cmpl_go;

  assign rd_idx  = {ren_t_i, ren_s3_i, ren_s2_i, ren_s1_i};
  assign old_t   = rd_dat[3];
  assign stall_o = free_empty | pend_full;
  assign accept  = ren_valid_i & ~stall_o;
  assign cmpl_go = cmpl_i & ~pend_empty;

  assign ren_accept_o = accept;
  assign phys_t_o     = free_head;
  assign phys_s1_o    = rd_dat[0];
  assign phys_s2_o    = rd_dat[1];
  assign phys_s3_o    = rd_dat[2];

  rn_map_table #(
    .NUM_ENT(NUM_ARCH), .IDX_W(AREG_W), .DAT_W(PREG_W), .NRD(NUM_RD)
  ) u_map (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_dat_o(rd_dat),
    .we_i(accept), .wr_idx_i(ren_t_i), .wr_dat_i(free_head)
  );

  rn_name_fifo #(
    .DEPTH(SPARE), .W(PREG_W), .INIT_FULL(1'b1), .INIT_BASE(NUM_ARCH)
  ) u_free (
    .clk_i, .rst_ni,
    .push_i(cmpl_go), .push_data_i(pend_head), .pop_i(accept),
    .head_o(free_head), .empty_o(free_empty), .full_o(free_full),
    .count_o(free_cnt)
  );

  rn_name_fifo #(
    .DEPTH(SPARE), .W(PREG_W), .INIT_FULL(1'b0), .INIT_BASE(0)
  ) u_pend (
    .clk_i, .rst_ni,
    .push_i(accept), .push_data_i(old_t), .pop_i(cmpl_go),
    .head_o(pend_head), .empty_o(pend_empty), .full_o(pend_full),
    .count_o(pend_cnt)
  );

  assert_names_conserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, free_cnt} + {1'b0, pend_cnt}) == (CNT_W + 1)'(SPARE));
  assert_full_free_empty_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_full |-> pend_empty);
  assert_stall_no_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && ren_valid_i) |=> (free_cnt >= $past(free_cnt)));
  assert_new_name_is_spare_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !free_empty |-> (free_head >= PREG_W'(NUM_ARCH)) || (free_head != old_t));
endmodule

// File: tb/rn_renamer_test.sv
`timescale 1ns/1ps
module rn_renamer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, cmpl = 1'b0;
  logic [4:0] t = '0, s1 = '0, s2 = '0, s3 = '0;
  logic acc, stall;
  logic [5:0] pt, ps1, ps2, ps3;

  int total = 0, bad = 0, cyc = 0;

  // reference model
  int map_m [32];
  int fq [8];
  int fcnt;
  int pq [8];
  int pcnt;

  always #2.5 clk = ~clk;

  rn_renamer uut (
    .clk_i(clk), .rst_ni(rst_n), .ren_valid_i(vld), .ren_t_i(t),
    .ren_s1_i(s1), .ren_s2_i(s2), .ren_s3_i(s3), .cmpl_i(cmpl),
    .ren_accept_o(acc), .stall_o(stall), .phys_t_o(pt),
    .phys_s1_o(ps1), .phys_s2_o(ps2), .phys_s3_o(ps3)
  );

  // {valid, cmpl, t, s1, s2, s3}
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b1,5'd0 ,5'd0 ,5'd0 ,5'd0 },  // R8 completion, nothing pending
    {1'b1,1'b0,5'd3 ,5'd3 ,5'd4 ,5'd5 },  // R3 source==target
    {1'b1,1'b0,5'd4 ,5'd3 ,5'd4 ,5'd3 },  // R4 sees new 3
    {1'b1,1'b0,5'd3 ,5'd3 ,5'd3 ,5'd3 },
    {1'b1,1'b0,5'd7 ,5'd1 ,5'd2 ,5'd31},
    {1'b1,1'b0,5'd8 ,5'd8 ,5'd9 ,5'd10},
    {1'b1,1'b0,5'd9 ,5'd3 ,5'd8 ,5'd0 },
    {1'b1,1'b0,5'd10,5'd9 ,5'd9 ,5'd9 },
    {1'b1,1'b0,5'd11,5'd11,5'd4 ,5'd3 },  // last free name
    {1'b1,1'b0,5'd12,5'd3 ,5'd4 ,5'd11},  // R6 R7 stall
    {1'b0,1'b0,5'd0 ,5'd12,5'd12,5'd12},  // R7 map of 12 untouched
    {1'b1,1'b1,5'd12,5'd3 ,5'd3 ,5'd3 },  // R9 complete during stall
    {1'b1,1'b1,5'd12,5'd12,5'd3 ,5'd4 },  // R9 rename + complete
    {1'b1,1'b0,5'd13,5'd12,5'd13,5'd3 },
    {1'b0,1'b1,5'd0 ,5'd13,5'd12,5'd11},
    {1'b0,1'b1,5'd0 ,5'd3 ,5'd4 ,5'd7 },
    {1'b1,1'b0,5'd3 ,5'd3 ,5'd3 ,5'd3 },  // R5 recycled name
    {1'b0,1'b1,5'd0 ,5'd0 ,5'd0 ,5'd0 },
    {1'b0,1'b1,5'd0 ,5'd0 ,5'd0 ,5'd0 },
    {1'b1,1'b1,5'd20,5'd3 ,5'd20,5'd4 },
    {1'b1,1'b0,5'd21,5'd20,5'd21,5'd9 },
    {1'b0,1'b0,5'd0 ,5'd20,5'd21,5'd3 }
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) map_m[i] = i;
    for (int i = 0; i < 8; i++) fq[i] = 32 + i;
    fcnt = 8;
    pcnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vld = 1'b0; cmpl = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // drive at negedge, check 1ns later, advance model at posedge
  task automatic step(input logic v, input logic c, input int tt, input int a,
                      input int b, input int d);
    int exp_stall, exp_acc, old, nm;
    bit cgo;
    @(negedge clk);
    vld = v; cmpl = c; t = 5'(tt); s1 = 5'(a); s2 = 5'(b); s3 = 5'(d);
    #1;
    exp_stall = (fcnt == 0 || pcnt == 8) ? 1 : 0;
    exp_acc   = (v && exp_stall == 0) ? 1 : 0;
    chk("R6 stall", int'(stall), exp_stall);
    chk("R10 accept", int'(acc), exp_acc);
    chk("R3 src1", int'(ps1), map_m[a]);
    chk("R3 src2", int'(ps2), map_m[b]);
    chk("R3 src3", int'(ps3), map_m[d]);
    if (fcnt > 0) chk("R2 target name", int'(pt), fq[0]);
    cgo = c && (pcnt > 0);
    @(posedge clk);
    nm = fq[0];
    old = map_m[tt];
    if (exp_acc == 1) begin
      for (int i = 0; i < 7; i++) fq[i] = fq[i+1];
      fcnt--;
    end
    if (cgo) begin
      fq[fcnt] = pq[0];
      fcnt++;
      for (int i = 0; i < 7; i++) pq[i] = pq[i+1];
      pcnt--;
    end
    if (exp_acc == 1) begin
      map_m[tt] = nm;
      pq[pcnt] = old;
      pcnt++;
    end
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed;
    model_reset();
    do_reset();

    // R1 reset mapping, R2 first free name
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      s1 = 5'(i); s2 = 5'(31 - i); s3 = 5'(i);
      #0.1;
      chk("R1 reset map", int'(ps1), i);
      chk("R1 reset map", int'(ps2), 31 - i);
    end
    chk("R1 stall after reset", int'(stall), 0);
    chk("R2 first free", int'(pt), 32);

    // vector table
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][21], VEC[k][20], int'(VEC[k][19:15]), int'(VEC[k][14:10]),
           int'(VEC[k][9:5]), int'(VEC[k][4:0]));
    end

    // R8 drain pending, extra strobes ignored
    repeat (12) step(1'b0, 1'b1, 0, 0, 1, 2);
    chk("R8 free full after drain", fcnt, 8);

    // R5 R4 long mixed run, several recycling laps
    seed = 7;
    for (int k = 0; k < 600; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step(seed[3] | seed[4], seed[5] & ~seed[9], seed[14:10], seed[19:15],
           seed[24:20], seed[29:25]);
    end

    // R6 fill until stall, then R7 valid ignored under stall
    repeat (10) step(1'b1, 1'b0, 5, 5, 6, 7);
    step(1'b1, 1'b0, 6, 6, 6, 6);
    step(1'b0, 1'b0, 0, 6, 5, 5);

    // R1 reset again mid-stream
    do_reset();
    step(1'b0, 1'b0, 0, 5, 6, 31);
    chk("R1 map after re-reset", map_m[5], 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule